// File: doc/BRIEF.md
# Paged Window Address Translator

This block turns a 16-bit CPU address into a 17-bit extended memory address. A fixed 16 KB window in the CPU map, from 0x8000 to 0xBFFF, shows one selectable 16 KB page of the extended space. A 3-bit page register picks that page. When the CPU address falls inside the window, the page number becomes the top three bits of the extended address and the low 14 address bits pass through as the offset. Every other CPU address maps straight into the bottom 64 KB of the extended space, zero-extended.

Because of this mapping, a physical location in the low 64 KB can be reached two ways: directly, or through the window with the matching page. For example, page 1 seen through the window covers the same locations as CPU addresses 0x4000 to 0x7FFF. The page register resets to 2. At that value the window shows the region that sits at the same place in the linear map, so software sees a flat 64 KB space until it changes the page.

The page register is written through a data port with a strobe and can always be read back. A write takes effect on the clock edge that samples it. Translation is combinational from the CPU address and the registered page value.

Top module: `paged_window_xlate`

## Requirements
- R1: After reset, the page read port shows page 2 (binary 010).
- R2: The window-hit flag is 1 for every CPU address from 0x8000 to 0xBFFF inclusive, and 0 for every other address.
- R3: On a window hit, the extended address is page × 0x4000 + (CPU address − 0x8000). That is, bits 16:14 hold the page and bits 13:0 hold CPU address bits 13:0.
- R4: Outside the window, the extended address equals the CPU address with bit 16 set to 0, whatever the page register holds.
- R5: When the write strobe is 1 at a rising clock edge, the page read port shows the written data from that edge on.
- R6: When the write strobe is 0, the value on the page data input has no effect: the page read port and every translation stay unchanged.
- R7: In the cycle where a page write is presented, translation still uses the old page. From the next cycle on, it uses the new page.
- R8: With page 1, each window address 0x8000+k gives the same extended address as the direct address 0x4000+k, for every k from 0 to 0x3FFF.
- R9: With the reset page, every window address gives an extended address equal to the CPU address itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the page register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address to translate |
| page_we | input | 1 | Page register write strobe |
| page_wdata | input | 3 | New page number |
| page_rdata | output | 3 | Current page register value |
| ext_addr | output | 17 | Translated extended address |
| win_hit | output | 1 | CPU address lies inside the paging window |

## Verification
Two functions can fall in the same cycle: a page-register write and a windowed translation. The bench provokes this by presenting a window address together with an active write strobe and a new page. Just after the input change, and before the clock edge, it checks that the extended address still carries the old page. Just after the edge, it checks that the address now carries the new page.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int CPU_AW = 16;
  localparam int OFF_W  = 14;
  localparam int PAGE_W = 3;
  localparam int IDX_W  = CPU_AW - OFF_W;
  localparam int EXT_AW = PAGE_W + OFF_W;
  localparam int PAD_W  = EXT_AW - CPU_AW;

  typedef logic [CPU_AW-1:0] cpu_addr_t;
  typedef logic [OFF_W-1:0]  offset_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [IDX_W-1:0]  win_idx_t;
  typedef logic [EXT_AW-1:0] ext_addr_t;

  // Window slot number of a CPU address (its top bits).
  function automatic win_idx_t slot_of(cpu_addr_t a);
    return a[CPU_AW-1:OFF_W];
  endfunction

  // Offset within a 16 KB page.
  function automatic offset_t offset_of(cpu_addr_t a);
    return a[OFF_W-1:0];
  endfunction

  // Linear (pass-through) mapping.
  function automatic ext_addr_t linear_of(cpu_addr_t a);
    return {{PAD_W{1'b0}}, a};
  endfunction

  // Paged mapping.
  function automatic ext_addr_t paged_of(page_t p, offset_t o);
    return {p, o};
  endfunction
endpackage

// File: rtl/pw_page_reg.sv
module pw_page_reg
  import pw_pkg::*;
#(
  parameter page_t RESET_PAGE = page_t'(2)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  page_t wdata,
  output page_t page_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  page_q <= RESET_PAGE;
    else if (we) page_q <= wdata;
  end
endmodule

// File: rtl/pw_window_decode.sv
module pw_window_decode
  import pw_pkg::*;
#(
  parameter win_idx_t WIN_INDEX = win_idx_t'(2)
) (
  input  cpu_addr_t addr,
  output logic      hit,
  output offset_t   offset
);
  assign hit    = (slot_of(addr) == WIN_INDEX);
  assign offset = offset_of(addr);
endmodule

// File: rtl/pw_addr_compose.sv
module pw_addr_compose
  import pw_pkg::*;
(
  input  cpu_addr_t addr,
  input  logic      hit,
  input  offset_t   offset,
  input  page_t     page,
  output ext_addr_t ext
);
  ext_addr_t linear_w;
  ext_addr_t paged_w;

  assign linear_w = linear_of(addr);
  assign paged_w  = paged_of(page, offset);
  assign ext      = hit ? paged_w : linear_w;
endmodule

// File: rtl/paged_window_xlate.sv
module paged_window_xlate
  import pw_pkg::*;
#(
  parameter page_t    RESET_PAGE = page_t'(2),
  parameter win_idx_t WIN_INDEX  = win_idx_t'(2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic                page_we,
  input  logic [PAGE_W-1:0]   page_wdata,
  output logic [PAGE_W-1:0]   page_rdata,
  output logic [EXT_AW-1:0]   ext_addr,
  output logic                win_hit
);
  page_t     page_cur;
  logic      window_hit_w;
  offset_t   window_off_w;
  ext_addr_t ext_w;

  pw_page_reg #(.RESET_PAGE(RESET_PAGE)) u_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (page_we),
    .wdata  (page_wdata),
    .page_q (page_cur)
  );

  pw_window_decode #(.WIN_INDEX(WIN_INDEX)) u_dec (
    .addr   (cpu_addr),
    .hit    (window_hit_w),
    .offset (window_off_w)
  );

  pw_addr_compose u_comp (
    .addr   (cpu_addr),
    .hit    (window_hit_w),
    .offset (window_off_w),
    .page   (page_cur),
    .ext    (ext_w)
  );

  assign page_rdata = page_cur;
  assign ext_addr   = ext_w;
  assign win_hit    = window_hit_w;
endmodule

// File: rtl/paged_window_xlate_chk.sv
module paged_window_xlate_chk
  import pw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              page_we,
  input logic [PAGE_W-1:0] page_wdata,
  input logic [PAGE_W-1:0] page_rdata,
  input logic [EXT_AW-1:0] ext_addr,
  input logic              win_hit
);
  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit == ((cpu_addr >= 16'h8000) && (cpu_addr < 16'hC000)));

  // R3
  paged_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (ext_addr == (EXT_AW'(page_rdata) * 17'h4000 + EXT_AW'(cpu_addr - 16'h8000))));

  // R4
  linear_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (ext_addr[CPU_AW-1:0] == cpu_addr && ext_addr[EXT_AW-1] == 1'b0));

  // R5
  page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> (page_rdata == $past(page_wdata)));

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we |=> $stable(page_rdata));
endmodule

bind paged_window_xlate paged_window_xlate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .page_we    (page_we),
  .page_wdata (page_wdata),
  .page_rdata (page_rdata),
  .ext_addr   (ext_addr),
  .win_hit    (win_hit)
);

// File: tb/test_paged_window_xlate.sv
`timescale 1ns/1ps
module test_paged_window_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        page_we = 1'b0;
  logic [2:0]  page_wdata = '0;
  logic [2:0]  page_rdata;
  logic [16:0] ext_addr;
  logic        win_hit;

  int checks = 0;
  int failures = 0;
  int printed = 0;

  always #4 clk = ~clk;

  paged_window_xlate i_paged_window_xlate (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .page_we(page_we),
    .page_wdata(page_wdata), .page_rdata(page_rdata),
    .ext_addr(ext_addr), .win_hit(win_hit)
  );

  function automatic int model_ext(int a, int p);
    if (a >= 32768 && a < 49152) return p * 16384 + (a - 32768);
    return a;
  endfunction

  function automatic bit model_hit(int a);
    return (a >= 32768) && (a < 49152);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      if (printed < 20) begin
        printed++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
    end
  endtask

  task automatic write_page(int p);
    @(negedge clk);
    page_we = 1'b1;
    page_wdata = 3'(p);
    @(negedge clk);
    page_we = 1'b0;
  endtask

  task automatic sweep(int p, string req);
    for (int a = 0; a < 65536; a++) begin
      cpu_addr = 16'(a);
      #0.05;
      check(win_hit == model_hit(a), "R2", int'(win_hit), int'(model_hit(a)));
      check(int'(ext_addr) == model_ext(a, p), req, int'(ext_addr), model_ext(a, p));
    end
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset page
    check(page_rdata == 3'd2, "R1", int'(page_rdata), 2);

    // R9: at reset page the window is linear
    for (int a = 32768; a < 49152; a += 37) begin
      cpu_addr = 16'(a);
      #0.05;
      check(int'(ext_addr) == a, "R9", int'(ext_addr), a);
    end
    sweep(2, "R3");

    // R5, R3, R4: every page, full address sweep
    for (int p = 0; p < 8; p++) begin
      write_page(p);
      #0.5;
      check(int'(page_rdata) == p, "R5", int'(page_rdata), p);
      sweep(p, (p % 2) ? "R3" : "R4");
    end

    // R8: page 1 aliases 0x4000..0x7FFF
    write_page(1);
    for (int k = 0; k < 16384; k++) begin
      cpu_addr = 16'(16384 + k);
      #0.05;
      cap = int'(ext_addr);
      cpu_addr = 16'(32768 + k);
      #0.05;
      check(int'(ext_addr) == cap, "R8", int'(ext_addr), cap);
    end

    // R6: data toggling without strobe has no effect
    write_page(6);
    cpu_addr = 16'h9ABC;
    for (int d = 0; d < 8; d++) begin
      @(negedge clk);
      page_wdata = 3'(d);
      @(posedge clk);
      #0.5;
      check(page_rdata == 3'd6, "R6", int'(page_rdata), 6);
      check(int'(ext_addr) == model_ext(16'h9ABC, 6), "R6",
            int'(ext_addr), model_ext(16'h9ABC, 6));
    end

    // R7: write and windowed translation in the same cycle
    @(negedge clk);
    cpu_addr = 16'h9234;
    page_we = 1'b1;
    page_wdata = 3'd5;
    #0.5;
    check(int'(ext_addr) == model_ext(16'h9234, 6), "R7",
          int'(ext_addr), model_ext(16'h9234, 6));
    @(posedge clk);
    #0.5;
    check(int'(ext_addr) == model_ext(16'h9234, 5), "R7",
          int'(ext_addr), model_ext(16'h9234, 5));
    @(negedge clk);
    page_we = 1'b0;
    // R7: back-to-back writes each seen one cycle later
    cpu_addr = 16'hB001;
    for (int p = 0; p < 8; p++) begin
      page_we = 1'b1;
      page_wdata = 3'(7 - p);
      @(posedge clk);
      #0.5;
      check(int'(ext_addr) == model_ext(16'hB001, 7 - p), "R7",
            int'(ext_addr), model_ext(16'hB001, 7 - p));
      @(negedge clk);
    end
    page_we = 1'b0;

    // R4: direct address ignores page changes
    cpu_addr = 16'hC123;
    write_page(3);
    #0.5;
    check(int'(ext_addr) == 16'hC123, "R4", int'(ext_addr), 16'hC123);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule